// File: doc/BRIEF.md
# Serial Configuration Target with Block Transfers

This block is a two-wire serial target that holds a small bank of 8-bit configuration bytes. Elsewhere on the chip, these bytes set which clock outputs are enabled and select the frequency. A host reaches the bank through one burst transfer in each direction. For a write, the host addresses the target and sends two header bytes. The target acknowledges both headers and discards their contents. After the headers, the host sends data that fills the bank from the lowest byte upwards. For a read, the target first returns a length byte and then the whole bank in ascending order.

The block runs from a fast system clock. It oversamples the serial clock and data lines and detects start and stop conditions from data edges while the serial clock is high. It only ever pulls the data line low, through an open-drain enable, and it never holds the serial clock low. The bus rate is standard mode, 100 kbit/s or less. The bank contents are always visible on a parallel output.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, `cfg_bytes` reads 48'h0F_FF_FF_FF_FF_00. Byte k sits in bits [8k+7:8k], so byte 0 is 00h, bytes 1 to 4 are FFh and byte 5 is 0Fh. `sda_oe` is low.
- R2: The 7-bit target address is 69h. The address byte is D2h for a write and D3h for a read. Any other address byte gets no acknowledge, and neither do the bytes that follow it. The bank does not change.
- R3: On a write, the target acknowledges the first two bytes after the address (a command byte and a length byte), whatever their values, and stores neither.
- R4: Each later write byte is acknowledged and stored, the first into byte 0 and each next one into the next higher byte. Bits arrive MSB first.
- R5: A stop ends a write after any complete byte, and the bytes already stored keep their new values. A byte cut short by a stop is not stored.
- R6: Write bytes beyond byte 5 are acknowledged and have no effect on the bank.
- R7: A read returns 06h first, then bytes 0 to 5 in order, MSB first, with the host acknowledging each byte.
- R8: When the host does not acknowledge a read byte, the target stops driving the data line until the next start.
- R9: `sda_oe` changes only while the serial clock is low.
- R10: A repeated start aborts the transfer in progress and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, pull the serial data line low |
| cfg_bytes | output | 48 | Configuration bank; byte k at bits [8k+7:8k] |

## Verification
A wrong byte pointer or a wrong bit count shows up at the ports within one byte time. Either the acknowledge is missing or misplaced in the ninth bit slot, or a value lands in the wrong byte of `cfg_bytes`, which is visible as soon as that byte's acknowledge starts. Read-back returns the bank through the bus, so any mismatch between what was stored and what is sent back appears during the next read. A pointer that is off by one shows as a shifted byte sequence after the 06h length byte. A target that fails to release after a host refusal holds the data line low, and the next bits read back as zeros instead of ones.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int              NBYTES   = 6,
  parameter logic [6:0]      DEV_ADDR = 7'h69,
  parameter logic [8*NBYTES-1:0] CFG_INIT = 48'h0F_FF_FF_FF_FF_00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NBYTES-1:0]   cfg_bytes
);

  localparam int IW = $clog2(NBYTES + 4) + 1;

  logic [2:0] scl_sr, sda_sr;
  logic       scl_q, scl_p, sda_q, sda_p;
  logic       scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end

  assign scl_q     = scl_sr[1];
  assign scl_p     = scl_sr[2];
  assign sda_q     = sda_sr[1];
  assign sda_p     = sda_sr[2];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

  logic                   busy, rd, oe;
  logic [3:0]             bitcnt;
  logic [IW-1:0]          idx, nxt;
  logic [7:0]             shreg, tx_next;
  logic [NBYTES-1:0][7:0] cfg;
  logic                   receiving;

  assign receiving = !(rd && idx != '0);
  assign nxt       = idx + 1'b1;

  always_comb begin
    tx_next = 8'hFF;
    if (nxt == IW'(1)) tx_next = 8'(NBYTES);
    for (int k = 0; k < NBYTES; k++)
      if (nxt == IW'(k + 2)) tx_next = cfg[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy   <= 1'b0;
      rd     <= 1'b0;
      oe     <= 1'b0;
      bitcnt <= '0;
      idx    <= '0;
      shreg  <= '0;
      cfg    <= CFG_INIT;
    end else if (start_det) begin
      busy   <= 1'b1;
      rd     <= 1'b0;
      oe     <= 1'b0;
      bitcnt <= '0;
      idx    <= '0;
    end else if (stop_det) begin
      busy <= 1'b0;
      oe   <= 1'b0;
    end else if (busy) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (receiving) shreg <= {shreg[6:0], sda_q};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (!receiving && sda_q) busy <= 1'b0;
        end
      end
      if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          if (idx == '0) begin
            if (shreg[7:1] == DEV_ADDR) begin
              oe <= 1'b1;
              rd <= shreg[0];
            end else begin
              busy <= 1'b0;
            end
          end else if (!rd) begin
            oe <= 1'b1;
            for (int k = 0; k < NBYTES; k++)
              if (idx == IW'(k + 3)) cfg[k] <= shreg;
          end else begin
            oe <= 1'b0;
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (idx != '1) idx <= nxt;
          if (rd) begin
            shreg <= tx_next;
            oe    <= ~tx_next[7];
          end else begin
            oe <= 1'b0;
          end
        end else if (bitcnt != 4'd0 && !receiving) begin
          oe    <= ~shreg[6];
          shreg <= {shreg[6:0], 1'b1};
        end
      end
    end

  assign sda_oe    = oe;
  assign cfg_bytes = cfg;

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) && !$past(start_det || stop_det) |-> !scl_q);

  a_r5_bank_changes_on_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> $past(busy && !rd && scl_fall && bitcnt == 4'd8 && !start_det && !stop_det));

  a_r2_quiet_during_address: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == '0 && bitcnt < 4'd8) |-> !oe);

  a_r8_release_after_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy && rd && idx != '0 && scl_rise && bitcnt == 4'd8 && sda_q && !start_det && !stop_det) |-> !oe && !busy);

  a_r4_bit_slot_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);

endmodule

// File: tb/sim_cfg_i2c_target.sv
module sim_cfg_i2c_target;

  localparam int Q  = 10;
  localparam int NV = 5;
  localparam int      VN [NV] = '{6, 2, 7, 0, 1};
  localparam logic [55:0] VD [NV] = '{
    56'h00_A5_5A_C3_3C_81_7E,
    56'h00_00_00_00_00_11_22,
    56'hEE_06_05_04_03_02_01,
    56'h00_00_00_00_00_00_00,
    56'h00_00_00_00_00_00_99 };
  localparam logic [7:0] VCMD [NV] = '{8'h00, 8'hFF, 8'h5C, 8'h01, 8'hA7};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl = 1'b1, sda_h = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg_bytes;
  wire         sda_ln = sda_h & ~sda_oe;

  cfg_i2c_target u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_ln),
                     .sda_oe(sda_oe), .cfg_bytes(cfg_bytes));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, r9_bad = 0;
  logic [7:0] mdl [6];
  logic       prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl) r9_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_h = b; waitq(1); scl = 1'b1; waitq(2); scl = 1'b0; waitq(1);
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; waitq(1); scl = 1'b1; waitq(1); b = sda_ln; waitq(1); scl = 1'b0; waitq(1);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; waitq(1); scl = 1'b1; waitq(1); sda_h = 1'b0; waitq(1); scl = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; waitq(1); scl = 1'b1; waitq(1); sda_h = 1'b1; waitq(2);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic rd_byte(input bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(last);
  endtask

  function automatic logic [47:0] mdl_vec();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = mdl[k];
    return v;
  endfunction

  task automatic read_back(input string tag);
    bit ak; logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, ak);
    chk(ak, {tag, " R2 read address acked"}, ak, 1);
    rd_byte(1'b0, b);
    chk(b == 8'h06, {tag, " R7 length byte"}, b, 8'h06);
    for (int k = 0; k < 6; k++) begin
      rd_byte(k == 5, b);
      chk(b == mdl[k], {tag, " R7 read-back byte"}, b, mdl[k]);
    end
    bus_stop();
  endtask

  initial begin
    bit ak; int acks; logic [7:0] b; logic x;
    mdl[0] = 8'h00; mdl[1] = 8'hFF; mdl[2] = 8'hFF;
    mdl[3] = 8'hFF; mdl[4] = 8'hFF; mdl[5] = 8'h0F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(cfg_bytes == 48'h0F_FF_FF_FF_FF_00, "R1 reset bank", cfg_bytes, 48'h0F_FF_FF_FF_FF_00);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);

    for (int v = 0; v < NV; v++) begin
      acks = 0;
      bus_start();
      wr_byte(8'hD2, ak); acks += int'(ak);
      wr_byte(VCMD[v], ak);
      chk(ak, "R3 command byte acked", ak, 1);
      wr_byte(~VCMD[v], ak);
      chk(ak, "R3 length byte acked", ak, 1);
      for (int i = 0; i < VN[v]; i++) begin
        wr_byte(VD[v][8*i +: 8], ak); acks += int'(ak);
        if (i < 6) mdl[i] = VD[v][8*i +: 8];
      end
      bus_stop();
      chk(acks == VN[v] + 1, "R4 R6 every write byte acked", acks, VN[v] + 1);
      chk(cfg_bytes == mdl_vec(), "R4 R6 bank after write", cfg_bytes, mdl_vec());
      read_back("vec");
    end

    bus_start();
    wr_byte(8'hA4, ak);
    chk(!ak, "R2 foreign address not acked", ak, 0);
    wr_byte(8'h12, ak);
    chk(!ak, "R2 byte after foreign address not acked", ak, 0);
    bus_stop();
    chk(cfg_bytes == mdl_vec(), "R2 bank unchanged", cfg_bytes, mdl_vec());

    bus_start();
    wr_byte(8'hD2, ak); wr_byte(8'h00, ak); wr_byte(8'h00, ak);
    wr_byte(8'h55, ak); mdl[0] = 8'h55;
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_stop();
    chk(cfg_bytes == mdl_vec(), "R5 partial byte dropped, full byte kept", cfg_bytes, mdl_vec());

    bus_start();
    wr_byte(8'hD3, ak);
    rd_byte(1'b1, b);
    chk(b == 8'h06, "R8 length before refusal", b, 8'h06);
    acks = 0;
    for (int i = 0; i < 8; i++) begin
      bit_in(x); acks += int'(x);
    end
    chk(acks == 8, "R8 line released after refusal", acks, 8);
    bus_stop();

    bus_start();
    wr_byte(8'hD2, ak); wr_byte(8'h3E, ak); wr_byte(8'h02, ak);
    wr_byte(8'hA1, ak); mdl[0] = 8'hA1;
    bus_start();
    wr_byte(8'hD3, ak);
    chk(ak, "R10 address after repeated start acked", ak, 1);
    rd_byte(1'b0, b);
    chk(b == 8'h06, "R10 length after repeated start", b, 8'h06);
    rd_byte(1'b1, b);
    chk(b == 8'hA1, "R10 byte 0 after repeated start", b, 8'hA1);
    bus_stop();
    read_back("final");

    chk(r9_bad == 0, "R9 sda_oe changes while SCL high", r9_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule